// File: doc/BRIEF.md
# Routed Four-Unit Timestamp Capture

This block time-tags signal edges. It has four capture units. Each unit watches one of 32 asynchronous input lines, and a field in the routing register chooses which line. The inputs pass through a two-flop synchroniser into the block clock domain. When a unit's chosen line shows a rising edge, the unit takes the current value of a free-running 32-bit timestamp counter. That counter advances on every clock edge where the external tick strobe is high.

A captured stamp waits in a one-entry slot for its unit. A fixed-priority drain moves one slot per cycle into a shared FIFO, starting with the lowest-numbered unit. Each FIFO word holds the unit number in its top two bits and the low 30 bits of the stamp.

Software reaches the block through four word registers: routing, control, data and status.
- Reading the data register pops the FIFO.
- Writing the data register clears the capture path.
- The status register reports the fill level, a sticky loss flag and the upper half of the control register.

Top module: `route_stamp_capture`

## Requirements
- R1: After `rst`, status, data, routing and control all read 0.
- R2: Unit u takes its source channel from routing bits [5u+4:5u]. A capture happens only on a rising edge of that channel. Falling edges and unselected channels capture nothing. The routing register reads back its 20 used bits, with bits 31..20 as 0.
- R3: A capture word is {unit[1:0], stamp[29:0]}. The stamp is the counter value after the second rising clk edge that samples the input high.
- R4: The counter advances by one on each clk edge where `ts_tick` is 1 and holds otherwise. A data-register write does not clear it.
- R5: Captures by several units in the same cycle enter the FIFO in ascending unit order, one word per cycle.
- R6: A data-register read (address 2) returns the oldest word and removes it. On an empty FIFO the read returns 0 and changes nothing.
- R7: A data-register write empties the FIFO, discards waiting captures and clears the loss flag. Routing and control are kept.
- R8: Status bits 14..0 (address 3) give the number of words in the FIFO.
- R9: A capture that finds the FIFO full is discarded and sets status bit 15. The bit stays set until the next data-register write.
- R10: The control register (address 1) reads back all 32 bits. Status bits 31..16 equal control bits 31..16.
- R11: A capture by a unit whose previous capture has not yet left its slot is discarded and sets status bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ts_tick | input | 1 | Counter advance strobe |
| sig_in | input | 32 | Asynchronous input lines |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | 0 routing, 1 control, 2 data, 3 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from address |

## Verification
The hardest case to reach from the ports is R11: a second capture arriving while the unit's slot still waits behind lower-numbered units. The bench routes the four units to four separate lines and raises all four lines together, so four slots fill in one cycle. It then pulls unit 3's line low for a single clock and raises it again. The second edge lands while unit 3 is still queued behind units 0 to 2. Random pulses on random routings, with several units sometimes sharing a line, cover the ordering and fill-level behaviour.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
    localparam int N_UNITS = 4;
    localparam int N_CH    = 32;
    localparam int SEL_W   = $clog2(N_CH);
    localparam int UNIT_W  = $clog2(N_UNITS);
    localparam int TS_W    = 32;
    localparam int WORD_W  = 32;
    localparam int KEEP_W  = WORD_W - UNIT_W;
    localparam int ROUTE_W = N_UNITS * SEL_W;

    typedef enum logic [1:0] {
        REG_ROUTE  = 2'd0,
        REG_CTRL   = 2'd1,
        REG_DATA   = 2'd2,
        REG_STATUS = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [UNIT_W-1:0] unit;
        logic [KEEP_W-1:0] stamp;
    } cap_word_t;

    function automatic cap_word_t make_word(input logic [UNIT_W-1:0] u,
                                           input logic [TS_W-1:0] ts);
        cap_word_t w;
        w.unit  = u;
        w.stamp = ts[KEEP_W-1:0];
        return w;
    endfunction

    function automatic logic [SEL_W-1:0] route_field(input logic [ROUTE_W-1:0] r,
                                                     input int u);
        return r[u*SEL_W +: SEL_W];
    endfunction
endpackage

// File: rtl/tsc_edge_sync.sv
module tsc_edge_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise = sync_q & ~prev_q;
endmodule

// File: rtl/tsc_unit_slot.sv
module tsc_unit_slot #(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            hit,
    input  logic [TS_W-1:0] ts_now,
    input  logic            drain,
    output logic            valid,
    output logic [TS_W-1:0] ts,
    output logic            lost
);
    logic busy;
    assign busy = valid && !drain;
    assign lost = hit && busy && !clr;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            valid <= 1'b0;
            ts    <= '0;
        end else if (hit && !busy) begin
            valid <= 1'b1;
            ts    <= ts_now;
        end else if (drain) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/tsc_fifo.sv
module tsc_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 32,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          can_take
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          full, pop_ok, push_ok;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty    = (count == '0);
    assign full     = (count == CW'(DEPTH));
    assign pop_ok   = pop && !empty;
    assign can_take = !full || pop_ok;
    assign push_ok  = push && can_take;
    assign head     = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/route_stamp_capture.sv
module route_stamp_capture
    import tsc_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ts_tick,
    input  logic [31:0] sig_in,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata
);
    logic [ROUTE_W-1:0] route_q;
    logic [31:0]        ctrl_q;
    logic [TS_W-1:0]    ts_q;
    logic               ovf_q;
    logic               soft_clr;
    logic [N_CH-1:0]    rise;
    logic [N_UNITS-1:0] hit, drain, slot_valid, slot_lost;
    logic [TS_W-1:0]    slot_ts [N_UNITS];
    logic [UNIT_W-1:0]  pick;
    logic               push_any;
    cap_word_t          push_word;
    logic [WORD_W-1:0]  fifo_head;
    logic [CW-1:0]      fifo_count;
    logic               fifo_empty, can_take, pop_req;
    reg_sel_e           sel;

    assign sel      = reg_sel_e'(reg_addr);
    assign soft_clr = reg_wr && (sel == REG_DATA);
    assign pop_req  = reg_rd && (sel == REG_DATA) && !soft_clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            route_q <= '0;
            ctrl_q  <= '0;
        end else if (reg_wr) begin
            if (sel == REG_ROUTE) route_q <= reg_wdata[ROUTE_W-1:0];
            if (sel == REG_CTRL)  ctrl_q  <= reg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          ts_q <= '0;
        else if (ts_tick) ts_q <= ts_q + 1'b1;
    end

    tsc_edge_sync #(.WIDTH(N_CH)) u_sync (
        .clk(clk), .rst(rst), .async_in(sig_in), .rise(rise)
    );

    for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
        assign hit[u] = rise[route_field(route_q, u)];
        tsc_unit_slot #(.TS_W(TS_W)) u_slot (
            .clk(clk), .rst(rst), .clr(soft_clr), .hit(hit[u]),
            .ts_now(ts_q), .drain(drain[u]), .valid(slot_valid[u]),
            .ts(slot_ts[u]), .lost(slot_lost[u])
        );
    end

    always_comb begin
        pick     = '0;
        push_any = 1'b0;
        drain    = '0;
        for (int u = N_UNITS - 1; u >= 0; u--) begin
            if (slot_valid[u]) begin
                pick     = UNIT_W'(u);
                push_any = 1'b1;
            end
        end
        if (push_any) drain[pick] = 1'b1;
        push_word = make_word(pick, slot_ts[pick]);
    end

    tsc_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_fifo (
        .clk(clk), .rst(rst), .clr(soft_clr), .push(push_any), .pop(pop_req),
        .wdata(push_word), .head(fifo_head), .count(fifo_count),
        .empty(fifo_empty), .can_take(can_take)
    );

    always_ff @(posedge clk) begin
        if (rst || soft_clr) ovf_q <= 1'b0;
        else if ((|slot_lost) || (push_any && !can_take)) ovf_q <= 1'b1;
    end

    always_comb begin
        case (sel)
            REG_ROUTE:  reg_rdata = 32'(route_q);
            REG_CTRL:   reg_rdata = ctrl_q;
            REG_DATA:   reg_rdata = fifo_empty ? '0 : fifo_head;
            default:    reg_rdata = {ctrl_q[31:16], ovf_q, 15'(fifo_count)};
        endcase
    end
endmodule

// File: rtl/tsc_capture_checker.sv
module tsc_capture_checker #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          reg_wr,
    input logic          reg_rd,
    input logic [1:0]    reg_addr,
    input logic [31:0]   reg_rdata,
    input logic [CW-1:0] fifo_count,
    input logic          ovf
);
    logic clr_req;
    assign clr_req = reg_wr && (reg_addr == 2'd2);

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (fifo_count == '0) && !ovf); // R1
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(fifo_count) <= DEPTH); // R8
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ($past(ovf) && !$past(clr_req)) |-> ovf); // R9
    AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(clr_req) |-> (fifo_count == '0) && !ovf); // R7
    AST_ONE_WORD_STEP: assert property (@(posedge clk) disable iff (rst)
        !$past(clr_req) |-> int'(fifo_count) <= int'($past(fifo_count)) + 1); // R5
    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && !reg_wr && reg_addr == 2'd2 && fifo_count == '0) |-> reg_rdata == 32'd0); // R6
endmodule

bind route_stamp_capture tsc_capture_checker #(.DEPTH(FIFO_DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_rdata(reg_rdata), .fifo_count(fifo_count), .ovf(ovf_q)
);

// File: tb/route_stamp_capture_bench.sv
module route_stamp_capture_bench;
    localparam int DEPTH = 16;

    logic        clk = 0;
    logic        rst = 1;
    logic        ts_tick = 1;
    logic [31:0] sig = '0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int checks = 0, failures = 0;
    bit done = 0;

    logic [31:0] m_cnt;
    logic [31:0] mq[$];
    bit          movf = 0;
    int          m_route[4];
    logic [31:0] m_ctrl = '0;

    always #5 clk = ~clk;

    route_stamp_capture #(.FIFO_DEPTH(DEPTH)) u_route_stamp_capture (
        .clk(clk), .rst(rst), .ts_tick(ts_tick), .sig_in(sig),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    always @(posedge clk) begin
        if (rst) m_cnt <= '0;
        else if (ts_tick) m_cnt <= m_cnt + 1;
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 0;
    endtask

    function automatic logic [31:0] exp_status();
        return {m_ctrl[31:16], movf, 15'(mq.size())};
    endfunction

    function automatic logic [31:0] exp_word(input int u, input logic [31:0] ts);
        return {u[1:0], ts[29:0]};
    endfunction

    function automatic void model_push(input logic [31:0] w);
        if (mq.size() < DEPTH) mq.push_back(w);
        else movf = 1;
    endfunction

    function automatic logic [31:0] model_pop();
        if (mq.size() == 0) return 32'd0;
        return mq.pop_front();
    endfunction

    task automatic set_route(input int r0, input int r1, input int r2, input int r3);
        m_route[0] = r0; m_route[1] = r1; m_route[2] = r2; m_route[3] = r3;
        wr(2'd0, 32'(r0) | (32'(r1) << 5) | (32'(r2) << 10) | (32'(r3) << 15));
    endtask

    task automatic pulse(input int ch, input bit ticking);
        logic [31:0] ts;
        @(negedge clk);
        ts = ticking ? m_cnt + 2 : m_cnt;
        sig[ch] = 1'b1;
        for (int u = 0; u < 4; u++)
            if (m_route[u] == ch) model_push(exp_word(u, ts));
        repeat (3) @(negedge clk);
        sig[ch] = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic drain_check(input string tag);
        logic [31:0] d;
        while (mq.size() > 0) begin
            rd(2'd2, d);
            check(tag, d, model_pop());
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog got=%h exp=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] ts;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 0;
        for (int u = 0; u < 4; u++) m_route[u] = 0;

        // R1 reset state
        rd(2'd3, d); check("R1 status", d, 32'd0);
        rd(2'd2, d); check("R1 data", d, 32'd0);
        rd(2'd0, d); check("R1 route", d, 32'd0);
        rd(2'd1, d); check("R1 ctrl", d, 32'd0);

        // R10 control and routing readback
        wr(2'd1, 32'hA5A5_1234); m_ctrl = 32'hA5A5_1234;
        rd(2'd1, d); check("R10 ctrl", d, 32'hA5A5_1234);
        rd(2'd3, d); check("R10 status upper", d, exp_status());
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, d); check("R2 route readback", d, 32'h000F_FFFF);

        // R2/R3 single capture on unit 2, others elsewhere
        set_route(5, 6, 9, 8);
        pulse(9, 1);
        rd(2'd3, d); check("R8 count one", d, exp_status());
        drain_check("R3 word format");
        // R2 unselected channel and falling edge give nothing
        pulse(20, 1);
        rd(2'd3, d); check("R2 unselected", d, exp_status());

        // R4 counter holds while tick low
        @(negedge clk); ts_tick = 0;
        pulse(5, 0);
        ts_tick = 1;
        drain_check("R4 frozen counter");

        // R5 all units on one channel
        set_route(11, 11, 11, 11);
        pulse(11, 1);
        rd(2'd3, d); check("R5 four words", d, exp_status());
        drain_check("R5 ascending order");

        // R6 empty read
        rd(2'd2, d); check("R6 empty read", d, 32'd0);
        rd(2'd3, d); check("R6 empty status", d, exp_status());

        // R9 overflow
        set_route(5, 6, 7, 8);
        for (int i = 0; i < DEPTH + 1; i++) pulse(5, 1);
        rd(2'd3, d); check("R9 full with flag", d, exp_status());
        check("R9 flag expected set", 32'(movf), 32'd1);
        drain_check("R9 kept words");
        rd(2'd2, d); check("R6 empty after drain", d, 32'd0);
        rd(2'd3, d); check("R9 flag sticky", d, exp_status());

        // R7 soft reset
        pulse(6, 1);
        wr(2'd2, 32'd0); mq.delete(); movf = 0;
        rd(2'd3, d); check("R7 status cleared", d, exp_status());
        rd(2'd2, d); check("R7 data empty", d, 32'd0);
        rd(2'd1, d); check("R7 ctrl kept", d, m_ctrl);
        rd(2'd0, d); check("R7 route kept", d, 32'd5 | (32'd6 << 5) | (32'd7 << 10) | (32'd8 << 15));
        pulse(7, 1);
        drain_check("R4 counter not cleared");

        // R11 capture onto a still-waiting slot
        set_route(0, 1, 2, 3);
        @(negedge clk);
        ts = m_cnt + 2;
        sig[3:0] = 4'hF;
        @(negedge clk); sig[3] = 0;
        @(negedge clk); sig[3] = 1;
        repeat (3) @(negedge clk);
        sig[3:0] = 4'h0;
        repeat (8) @(negedge clk);
        for (int u = 0; u < 4; u++) model_push(exp_word(u, ts));
        movf = 1;
        rd(2'd3, d); check("R11 lost capture flag", d, exp_status());
        drain_check("R11 words");
        wr(2'd2, 32'd0); movf = 0;

        // random traffic
        for (int it = 0; it < 80; it++) begin
            int r;
            if (it % 20 == 0)
                set_route($urandom % 32, $urandom % 32, $urandom % 32, $urandom % 32);
            r = $urandom % 4;
            if (r < 2) pulse($urandom % 32, 1);
            else if (r == 2) begin
                rd(2'd2, d); check("R6 random read", d, model_pop());
            end else begin
                rd(2'd3, d); check("R8 random status", d, exp_status());
            end
        end
        drain_check("R5 random drain");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule